// File: doc/BRIEF.md
# Parity-Keyed Marker Rotation Codec

This block sits in a serial link's word path. Every link word holds two data bytes plus a 2-bit marker. A data word uses only the marker values 00, 01 and 10. The value 11 is kept for the start of a control packet. On the transmit side the block takes the parity of each byte and reduces the pair to one of three codes with an AND and an OR gate. That code chooses a permutation of the three data marker values. The parity is therefore carried inside the marker, and no permutation can produce 11. A word that already carries marker 11 is a control word and goes through unchanged.

The receive side recomputes both byte parities from the bytes it was given. It applies the inverse permutation and returns the original marker. It also compares that marker with the value the link expects in that slot; the expected value comes in as an input. If a byte was corrupted, the recovered marker usually differs from the expected one, and the error flag goes high in the same cycle as the word. Each side is one register stage with an active-high valid.

Top module: `marker_rot_codec`

## Requirements
- R1: While rst_n is low and in the first cycle after it, txValidOut, rxValidOut and rxErr are 0.
- R2: Each side has one cycle of latency. A valid output equals its valid input from the previous cycle, and the output bytes equal the input bytes from that cycle.
- R3: Encoder with both byte parities even (parity = XOR of a byte's bits, byte 0 = bits 7:0, byte 1 = bits 15:8). A data marker comes out unchanged.
- R4: Encoder with exactly one byte parity odd. The marker rotates: 00→01, 01→10, 10→00.
- R5: Encoder with both byte parities odd. The marker maps 00→10, 01→01, 10→00.
- R6: An encoder input marker of 11 comes out as 11 whatever the parities are. A data marker never comes out as 11.
- R7: The decoder inverts R3–R5 using its own parities. A valid receive marker of 11 comes out as 11. Every byte pair with every data marker, once encoded and then decoded unchanged, returns its original marker.
- R8: rxErr is 1 in exactly those cycles where rxValidOut is 1 and the recovered marker differs from the expected marker that was sampled with the word.
- R9: Flipping any single byte bit between encoder and decoder changes the recovered data marker. The one exception is marker 10 when the parity pair moves between one-odd and both-odd: both permutations send 10 to 00, so that case is not detected.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txValidIn | input | 1 | Transmit word valid |
| txDataIn | input | 16 | Transmit byte pair |
| txMarkIn | input | 2 | Transmit marker before encoding |
| txValidOut | output | 1 | Encoded word valid |
| txDataOut | output | 16 | Encoded byte pair (unchanged bytes) |
| txMarkOut | output | 2 | Parity-keyed marker |
| rxValidIn | input | 1 | Received word valid |
| rxDataIn | input | 16 | Received byte pair |
| rxMarkIn | input | 2 | Received encoded marker |
| rxExpMark | input | 2 | Marker expected in this slot |
| rxValidOut | output | 1 | Decoded word valid |
| rxDataOut | output | 16 | Decoded byte pair |
| rxMarkOut | output | 2 | Recovered marker |
| rxErr | output | 1 | Recovered marker differs from expected |

## Verification
Several properties are checked on every cycle: the valid and data latency, that a data marker never turns into 11, that control markers pass through on both sides, that an even-parity marker passes through, and that rxErr only appears together with a valid. Other behaviour can only be shown by the bench's scenarios. This covers the rotation tables for the mixed and both-odd parity codes, and the round trip over random and corner-case byte pairs. It also covers the single-bit corruption experiments, which include the one mapping where corruption is not detected.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  typedef logic [1:0] mark_t;

  localparam mark_t MARK_CTRL = 2'b11;

  typedef enum logic [1:0] {
    PC_EVEN  = 2'b00,
    PC_MIXED = 2'b01,
    PC_BOTH  = 2'b11
  } parCode_t;

  typedef struct packed {
    logic txLoad;
    logic rxLoad;
    logic rxErrArm;
  } strobes_t;

  function automatic mark_t rotLeft(input mark_t m);
    case (m)
      2'b00:   rotLeft = 2'b01;
      2'b01:   rotLeft = 2'b10;
      2'b10:   rotLeft = 2'b00;
      default: rotLeft = m;
    endcase
  endfunction

  function automatic mark_t rotRight(input mark_t m);
    case (m)
      2'b00:   rotRight = 2'b10;
      2'b01:   rotRight = 2'b00;
      2'b10:   rotRight = 2'b01;
      default: rotRight = m;
    endcase
  endfunction

  function automatic mark_t swapBits(input mark_t m);
    swapBits = {m[0], m[1]};
  endfunction

endpackage

// File: rtl/mrc_parity.sv
module mrc_parity
  import mrc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] data,
  output parCode_t            code
);
  localparam int LANES = 2;

  logic [LANES-1:0] par;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign par[g] = ^data[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  logic andBit;
  logic orBit;

  assign andBit = &par;
  assign orBit  = |par;

  always_comb begin
    case ({andBit, orBit})
      2'b00:   code = PC_EVEN;
      2'b01:   code = PC_MIXED;
      default: code = PC_BOTH;
    endcase
  end
endmodule

// File: rtl/mrc_ctrl.sv
module mrc_ctrl
  import mrc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     txValidIn,
  input  logic     rxValidIn,
  output strobes_t strobes,
  output logic     txValidOut,
  output logic     rxValidOut
);
  assign strobes.txLoad   = txValidIn;
  assign strobes.rxLoad   = rxValidIn;
  assign strobes.rxErrArm = rxValidIn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txValidOut <= 1'b0;
      rxValidOut <= 1'b0;
    end else begin
      txValidOut <= txValidIn;
      rxValidOut <= rxValidIn;
    end
  end
endmodule

// File: rtl/mrc_datapath.sv
module mrc_datapath
  import mrc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobes_t            strobes,
  input  logic [2*BYTE_W-1:0] txDataIn,
  input  mark_t               txMarkIn,
  output logic [2*BYTE_W-1:0] txDataOut,
  output mark_t               txMarkOut,
  input  logic [2*BYTE_W-1:0] rxDataIn,
  input  mark_t               rxMarkIn,
  input  mark_t               rxExpMark,
  output logic [2*BYTE_W-1:0] rxDataOut,
  output mark_t               rxMarkOut,
  output logic                rxErr
);
  localparam int DATA_W = 2 * BYTE_W;

  parCode_t txCode;
  parCode_t rxCode;
  mark_t    txMarkNext;
  mark_t    rxMarkNext;

  mrc_parity #(.BYTE_W(BYTE_W)) u_txPar (.data(txDataIn), .code(txCode));
  mrc_parity #(.BYTE_W(BYTE_W)) u_rxPar (.data(rxDataIn), .code(rxCode));

  always_comb begin
    if (txMarkIn == MARK_CTRL) begin
      txMarkNext = txMarkIn;
    end else begin
      case (txCode)
        PC_EVEN:  txMarkNext = txMarkIn;
        PC_MIXED: txMarkNext = rotLeft(txMarkIn);
        default:  txMarkNext = swapBits(rotLeft(txMarkIn));
      endcase
    end
  end

  always_comb begin
    if (rxMarkIn == MARK_CTRL) begin
      rxMarkNext = rxMarkIn;
    end else begin
      case (rxCode)
        PC_EVEN:  rxMarkNext = rxMarkIn;
        PC_MIXED: rxMarkNext = rotRight(rxMarkIn);
        default:  rxMarkNext = rotRight(swapBits(rxMarkIn));
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txDataOut <= '0;
      txMarkOut <= '0;
    end else if (strobes.txLoad) begin
      txDataOut <= txDataIn;
      txMarkOut <= txMarkNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxDataOut <= {DATA_W{1'b0}};
      rxMarkOut <= '0;
      rxErr     <= 1'b0;
    end else begin
      rxErr <= strobes.rxErrArm && (rxMarkNext != rxExpMark);
      if (strobes.rxLoad) begin
        rxDataOut <= rxDataIn;
        rxMarkOut <= rxMarkNext;
      end
    end
  end
endmodule

// File: rtl/marker_rot_codec.sv
module marker_rot_codec
  import mrc_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txValidIn,
  input  logic [DATA_W-1:0] txDataIn,
  input  logic [1:0]        txMarkIn,
  output logic              txValidOut,
  output logic [DATA_W-1:0] txDataOut,
  output logic [1:0]        txMarkOut,
  input  logic              rxValidIn,
  input  logic [DATA_W-1:0] rxDataIn,
  input  logic [1:0]        rxMarkIn,
  input  logic [1:0]        rxExpMark,
  output logic              rxValidOut,
  output logic [DATA_W-1:0] rxDataOut,
  output logic [1:0]        rxMarkOut,
  output logic              rxErr
);
  strobes_t strobes;

  mrc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .txValidIn (txValidIn),
    .rxValidIn (rxValidIn),
    .strobes   (strobes),
    .txValidOut(txValidOut),
    .rxValidOut(rxValidOut)
  );

  mrc_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .txDataIn (txDataIn),
    .txMarkIn (txMarkIn),
    .txDataOut(txDataOut),
    .txMarkOut(txMarkOut),
    .rxDataIn (rxDataIn),
    .rxMarkIn (rxMarkIn),
    .rxExpMark(rxExpMark),
    .rxDataOut(rxDataOut),
    .rxMarkOut(rxMarkOut),
    .rxErr    (rxErr)
  );
endmodule

// File: rtl/marker_rot_codec_chk.sv
module marker_rot_codec_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txValidIn,
  input logic [DATA_W-1:0] txDataIn,
  input logic [1:0]        txMarkIn,
  input logic              txValidOut,
  input logic [DATA_W-1:0] txDataOut,
  input logic [1:0]        txMarkOut,
  input logic              rxValidIn,
  input logic [DATA_W-1:0] rxDataIn,
  input logic [1:0]        rxMarkIn,
  input logic              rxValidOut,
  input logic [DATA_W-1:0] rxDataOut,
  input logic [1:0]        rxMarkOut,
  input logic              rxErr
);
  localparam int HALF = DATA_W / 2;

  logic txEven;
  assign txEven = !(^txDataIn[HALF-1:0]) && !(^txDataIn[DATA_W-1:HALF]);

  AST_TX_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    txValidIn |=> txValidOut); // R2
  AST_RX_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    !rxValidIn |=> !rxValidOut); // R2
  AST_TX_DATA_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    txValidIn |=> txDataOut == $past(txDataIn)); // R2
  AST_RX_DATA_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    rxValidIn |=> rxDataOut == $past(rxDataIn)); // R2
  AST_TX_EVEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (txValidIn && txMarkIn != 2'b11 && txEven) |=> txMarkOut == $past(txMarkIn)); // R3
  AST_TX_CTRL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (txValidIn && txMarkIn == 2'b11) |=> txMarkOut == 2'b11); // R6
  AST_TX_NO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (txValidIn && txMarkIn != 2'b11) |=> txMarkOut != 2'b11); // R6
  AST_RX_CTRL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rxValidIn && rxMarkIn == 2'b11) |=> rxMarkOut == 2'b11); // R7
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rxErr |-> rxValidOut); // R8
endmodule

bind marker_rot_codec marker_rot_codec_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_marker_rot_codec.sv
module sim_marker_rot_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txValidIn = 1'b0;
  logic [15:0] txDataIn = '0;
  logic [1:0]  txMarkIn = '0;
  logic        txValidOut;
  logic [15:0] txDataOut;
  logic [1:0]  txMarkOut;
  logic        rxValidIn = 1'b0;
  logic [15:0] rxDataIn = '0;
  logic [1:0]  rxMarkIn = '0;
  logic [1:0]  rxExpMark = '0;
  logic        rxValidOut;
  logic [15:0] rxDataOut;
  logic [1:0]  rxMarkOut;
  logic        rxErr;

  int runCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  marker_rot_codec u0 (.*);

  function automatic int pclass(input logic [15:0] d);
    return int'(^d[7:0]) + int'(^d[15:8]);
  endfunction

  function automatic logic [1:0] encModel(input logic [15:0] d, input logic [1:0] m);
    if (m == 2'b11) return m;
    case (pclass(d))
      0: return m;
      1: return (m == 2'b00) ? 2'b01 : (m == 2'b01) ? 2'b10 : 2'b00;
      default: return (m == 2'b00) ? 2'b10 : (m == 2'b01) ? 2'b01 : 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] decModel(input logic [15:0] d, input logic [1:0] m);
    if (m == 2'b11) return m;
    case (pclass(d))
      0: return m;
      1: return (m == 2'b01) ? 2'b00 : (m == 2'b10) ? 2'b01 : 2'b10;
      default: return (m == 2'b10) ? 2'b00 : (m == 2'b01) ? 2'b01 : 2'b10;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doTx(input logic [15:0] d, input logic [1:0] m, input string tag);
    @(negedge clk);
    txValidIn = 1'b1; txDataIn = d; txMarkIn = m;
    @(negedge clk);
    txValidIn = 1'b0;
    check(txValidOut == 1'b1, {tag, " R2 txValid"}, txValidOut, 1);
    check(txDataOut == d, {tag, " R2 txData"}, txDataOut, d);
    check(txMarkOut == encModel(d, m), tag, txMarkOut, encModel(d, m));
  endtask

  task automatic doRx(input logic [15:0] d, input logic [1:0] m, input logic [1:0] e,
                      input string tag);
    logic [1:0] want;
    want = decModel(d, m);
    @(negedge clk);
    rxValidIn = 1'b1; rxDataIn = d; rxMarkIn = m; rxExpMark = e;
    @(negedge clk);
    rxValidIn = 1'b0;
    check(rxValidOut == 1'b1 && rxDataOut == d, {tag, " R2 rxData"}, rxDataOut, d);
    check(rxMarkOut == want, tag, rxMarkOut, want);
    check(rxErr == (want != e), {tag, " R8 err"}, rxErr, want != e);
  endtask

  task automatic roundTrip(input logic [15:0] d, input logic [1:0] m);
    logic [1:0] enc;
    doTx(d, m, "R7 enc");
    enc = txMarkOut;
    check(enc != 2'b11, "R6 no ctrl", enc, 0);
    doRx(d, enc, m, "R7 dec");
    check(rxMarkOut == m && !rxErr, "R7 roundtrip", rxMarkOut, m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(txValidOut == 0 && rxValidOut == 0 && rxErr == 0, "R1 in reset",
          {txValidOut, rxValidOut, rxErr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(txValidOut == 0 && rxValidOut == 0 && rxErr == 0, "R1 after reset",
          {txValidOut, rxValidOut, rxErr}, 0);

    // directed encoder tables
    doTx(16'h0000, 2'b00, "R3 even 00");
    doTx(16'h0303, 2'b10, "R3 even 10");
    doTx(16'h0001, 2'b00, "R4 mixed 00");
    doTx(16'h0100, 2'b01, "R4 mixed 01");
    doTx(16'h0001, 2'b10, "R4 mixed 10");
    doTx(16'h0101, 2'b00, "R5 both 00");
    doTx(16'h0780, 2'b01, "R5 both 01");
    doTx(16'h8001, 2'b10, "R5 both 10");
    check(txMarkOut == 2'b00, "R5 10 to 00", txMarkOut, 0);
    doTx(16'h0001, 2'b11, "R6 ctrl mixed");
    doTx(16'h0101, 2'b11, "R6 ctrl both");
    doRx(16'h0101, 2'b11, 2'b11, "R7 rx ctrl");
    doRx(16'h0001, 2'b00, 2'b01, "R8 mismatch");

    // idle: valid must drop and err must clear
    @(negedge clk);
    check(txValidOut == 0 && rxValidOut == 0 && rxErr == 0, "R2 idle",
          {txValidOut, rxValidOut, rxErr}, 0);

    // round trip, parity corners then random
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 3; m++)
        roundTrip({7'd0, c[1], 7'd0, c[0]}, 2'(m));
    for (int i = 0; i < 1500; i++)
      roundTrip(16'($urandom), 2'($urandom_range(0, 2)));

    // single-bit corruption
    for (int i = 0; i < 400; i++) begin
      logic [15:0] d, bad;
      logic [1:0] m, enc;
      int b, pc0, pc1;
      bit undetect;
      d = 16'($urandom);
      m = 2'($urandom_range(0, 2));
      b = $urandom_range(0, 15);
      bad = d ^ (16'h1 << b);
      doTx(d, m, "R9 enc");
      enc = txMarkOut;
      pc0 = pclass(d); pc1 = pclass(bad);
      undetect = (m == 2'b10) && (pc0 + pc1 == 3);
      doRx(bad, enc, m, "R9 dec");
      check((rxMarkOut == m) == undetect, "R9 corruption", rxMarkOut, m);
    end

    done = 1'b1;
  end

  initial begin : seedInit
    int s;
    s = $urandom(32'h5EED_0042);
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule